// File: doc/BRIEF.md
# Vectored Interrupt Controller

This peripheral gathers sixteen level-sensitive interrupt source lines and drives a single active-low interrupt request towards a processor. Each source has an enable bit, a 4-bit urgency level and a 32-bit handler start address, all set through a small word-addressed register bus. The request line is low whenever at least one enabled, active source is urgent enough to be taken.

When the processor wants to enter a handler it raises an address request. The controller picks the most urgent eligible source, freezes that choice, and presents its handler address for one cycle with a valid strobe. If nothing is eligible, a programmable default address is presented. When the processor acknowledges, the chosen source's level is pushed on an in-service stack. From then on only sources with a strictly higher level can pull the request line low, so the processor can re-enable interrupts without clearing the source. Any write to the end-of-service register pops the most recent level and re-opens lower levels. This permits nesting.

A larger level value means more urgent. Equal levels are resolved in favour of the lower source index.

Top module: `vec_irq_ctrl`

## Requirements
- R1: While reset is applied and after it is released, `irq_n` is 1, `vec_vld` is 0, the enable register reads 0 and the status register reads 0 (empty stack).
- R2: `irq_n` is 0 one clock after, and only while, some source is active, enabled and eligible. A source is eligible when the stack is empty or its level is strictly greater than the top stack level.
- R3: A source whose enable bit (bit i of register 0x00) is 0 never pulls `irq_n` low and is never selected.
- R4: When `vec_req` is sampled high in the idle state, `vec_vld` is 1 for exactly the next cycle. `vec_addr` then carries the handler address of the eligible source with the largest level, with ties going to the lowest index.
- R5: The selection is frozen when `vec_vld` is issued. Source changes after that point do not alter `vec_addr` or which source is recorded on acknowledge.
- R6: A `vec_ack` pulse after a source was presented pushes it as in service. Afterwards that source, and any source of equal or lower level, leaves `irq_n` high.
- R7: A write of any value to register 0x02 pops the most recent in-service entry, and lower levels become eligible again.
- R8: If no source is eligible when the request is sampled, `vec_addr` is the default address (register 0x01), and the acknowledge pushes nothing.
- R9: The bus read data appears one cycle after `bus_rd`. Register layout: 0x00 enable mask, 0x01 default address, 0x10+i level of source i (low 4 bits), 0x20+i handler of source i.
- R10: Nested entries stack. Status register 0x03 reads the stack depth in bits [12:8] and the top entry's source index in bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_irq | input | 16 | Active-high source request lines |
| irq_n | output | 1 | Combined active-low interrupt request |
| vec_req | input | 1 | Processor asks for a handler address |
| vec_vld | output | 1 | One-cycle strobe qualifying `vec_addr` |
| vec_addr | output | 32 | Handler start address |
| vec_ack | input | 1 | Processor has accepted the presented address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |

## Verification
The assertions assume that the processor holds `vec_req` until it acknowledges, and that `vec_ack` only arrives while the controller waits for it after a valid strobe. They also assume that sources and bus strobes are synchronous to `clk`. The stimulus changes all inputs on the falling edge. It always runs the complete request, strobe and acknowledge sequence, and drops the request in the same cycle as the acknowledge. As a result, the handshake never starts twice and the in-service stack cannot overflow.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_PRESENT = 2'd1,
    HS_WAIT    = 2'd2
  } hs_state_e;

  localparam logic [1:0] PAGE_CTRL = 2'd0;
  localparam logic [1:0] PAGE_LVL  = 2'd1;
  localparam logic [1:0] PAGE_HDL  = 2'd2;

  localparam int CTRL_ENABLE  = 0;
  localparam int CTRL_DEFAULT = 1;
  localparam int CTRL_EOS     = 2;
  localparam int CTRL_STATUS  = 3;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSRC   = 16,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        cand,
  input  logic [NSRC*PRIO_W-1:0] lvl_flat,
  output logic                   any,
  output logic [IDX_W-1:0]       win_idx
);
  logic [PRIO_W-1:0] best;

  // Strict comparison keeps the lowest index on a tie.
  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    best    = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!any || lvl_flat[i*PRIO_W +: PRIO_W] > best)) begin
        any     = 1'b1;
        win_idx = IDX_W'(i);
        best    = lvl_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack #(
  parameter int DEPTH  = 16,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_lvl,
  input  logic [IDX_W-1:0]  push_idx,
  input  logic              pop,
  output logic              empty,
  output logic [CNT_W-1:0]  count,
  output logic [PRIO_W-1:0] top_lvl,
  output logic [IDX_W-1:0]  top_idx
);
  logic [PRIO_W-1:0] lvl_q [DEPTH];
  logic [IDX_W-1:0]  idx_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              do_pop, do_push;
  logic [PTR_W-1:0]  wr_ptr, top_ptr;

  always_comb begin
    do_pop  = pop && (cnt_q != '0);
    do_push = push && ((cnt_q != CNT_W'(DEPTH)) || do_pop);
    cnt_d   = cnt_q;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    wr_ptr  = PTR_W'(cnt_q - CNT_W'(do_pop));
    top_ptr = PTR_W'(cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        lvl_q[e] <= '0;
        idx_q[e] <= '0;
      end
    end else begin
      cnt_q <= cnt_d;
      if (do_push) begin
        lvl_q[wr_ptr] <= push_lvl;
        idx_q[wr_ptr] <= push_idx;
      end
    end
  end

  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;
  assign top_lvl = empty ? '0 : lvl_q[top_ptr];
  assign top_idx = empty ? '0 : idx_q[top_ptr];

  // R6: a push never meets a full stack that is not also popping
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != CNT_W'(DEPTH)) || pop);
  // R10: nested entries are strictly more urgent than the one below
  a_r10_nest_strict: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && cnt_q != '0) |-> (push_lvl > top_lvl));
  // R7: a lone pop on a non-empty stack lowers the depth by one
  a_r7_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import vic_pkg::*;
#(
  parameter int NSRC    = 16,
  parameter int PRIO_W  = 4,
  parameter int DATA_W  = 32,
  parameter int BADDR_W = 6,
  parameter int CNT_W   = 5,
  localparam int IDX_W  = $clog2(NSRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [BADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [CNT_W-1:0]       stk_count,
  input  logic [IDX_W-1:0]       stk_top_idx,
  output logic [NSRC-1:0]        en_mask,
  output logic [DATA_W-1:0]      dflt_addr,
  output logic [NSRC*PRIO_W-1:0] lvl_flat,
  output logic [NSRC*DATA_W-1:0] hdl_flat,
  output logic                   eos_pulse
);
  logic [1:0]        page;
  logic [IDX_W-1:0]  slot;
  logic              wr_en, wr_dflt, wr_lvl, wr_hdl;
  logic [DATA_W-1:0] rd_d, rd_q;

  assign page    = bus_addr[BADDR_W-1 -: 2];
  assign slot    = bus_addr[IDX_W-1:0];
  assign wr_en   = bus_wr && page == PAGE_CTRL && slot == IDX_W'(CTRL_ENABLE);
  assign wr_dflt = bus_wr && page == PAGE_CTRL && slot == IDX_W'(CTRL_DEFAULT);
  assign eos_pulse = bus_wr && page == PAGE_CTRL && slot == IDX_W'(CTRL_EOS);
  assign wr_lvl  = bus_wr && page == PAGE_LVL;
  assign wr_hdl  = bus_wr && page == PAGE_HDL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_mask   <= '0;
      dflt_addr <= '0;
    end else begin
      if (wr_en)   en_mask   <= bus_wdata[NSRC-1:0];
      if (wr_dflt) dflt_addr <= bus_wdata;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_flat[i*PRIO_W +: PRIO_W] <= '0;
        hdl_flat[i*DATA_W +: DATA_W] <= '0;
      end else begin
        if (wr_lvl && slot == IDX_W'(i)) lvl_flat[i*PRIO_W +: PRIO_W] <= bus_wdata[PRIO_W-1:0];
        if (wr_hdl && slot == IDX_W'(i)) hdl_flat[i*DATA_W +: DATA_W] <= bus_wdata;
      end
    end
  end

  always_comb begin
    rd_d = '0;
    case (page)
      PAGE_CTRL: begin
        if (slot == IDX_W'(CTRL_ENABLE))  rd_d = DATA_W'(en_mask);
        if (slot == IDX_W'(CTRL_DEFAULT)) rd_d = dflt_addr;
        if (slot == IDX_W'(CTRL_STATUS)) begin
          rd_d[12:8]      = 5'(stk_count);
          rd_d[IDX_W-1:0] = stk_top_idx;
        end
      end
      PAGE_LVL: rd_d = DATA_W'(lvl_flat[slot*PRIO_W +: PRIO_W]);
      PAGE_HDL: rd_d = hdl_flat[slot*DATA_W +: DATA_W];
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (bus_rd) rd_q <= rd_d;
  end

  assign bus_rdata = rd_q;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NSRC    = 16,
  parameter int PRIO_W  = 4,
  parameter int DATA_W  = 32,
  parameter int BADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    src_irq,
  output logic               irq_n,
  input  logic               vec_req,
  output logic               vec_vld,
  output logic [DATA_W-1:0]  vec_addr,
  input  logic               vec_ack,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [BADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata
);
  localparam int IDX_W = $clog2(NSRC);
  localparam int LVLS  = 1 << PRIO_W;
  localparam int CNT_W = $clog2(LVLS + 1);

  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic [NSRC-1:0]        en_mask;
  logic [DATA_W-1:0]      dflt_addr;
  logic [NSRC*PRIO_W-1:0] lvl_flat;
  logic [NSRC*DATA_W-1:0] hdl_flat;
  logic                   eos_pulse;
  logic                   stk_empty;
  logic [CNT_W-1:0]       stk_count;
  logic [PRIO_W-1:0]      stk_top_lvl;
  logic [IDX_W-1:0]       stk_top_idx;
  logic [NSRC-1:0]        cand;
  logic                   win_any;
  logic [IDX_W-1:0]       win_idx;

  irq_cfg_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W),
                 .BADDR_W(BADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .stk_count(stk_count), .stk_top_idx(stk_top_idx),
    .en_mask(en_mask), .dflt_addr(dflt_addr), .lvl_flat(lvl_flat),
    .hdl_flat(hdl_flat), .eos_pulse(eos_pulse)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_elig
    assign cand[i] = src_irq[i] && en_mask[i] &&
                     (stk_empty || lvl_flat[i*PRIO_W +: PRIO_W] > stk_top_lvl);
  end

  irq_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_pick (
    .cand(cand), .lvl_flat(lvl_flat), .any(win_any), .win_idx(win_idx)
  );

  // Handshake: next-state logic and registers kept apart.
  hs_state_e         state_q, state_d;
  logic              vld_q, vld_d;
  logic [DATA_W-1:0] addr_q, addr_d;
  logic [IDX_W-1:0]  sel_idx_q, sel_idx_d;
  logic              sel_hit_q, sel_hit_d;
  logic              irq_n_q, irq_n_d;
  logic              push;

  always_comb begin
    state_d   = state_q;
    vld_d     = 1'b0;
    addr_d    = addr_q;
    sel_idx_d = sel_idx_q;
    sel_hit_d = sel_hit_q;
    irq_n_d   = ~|cand;
    case (state_q)
      HS_IDLE: if (vec_req) begin
        state_d   = HS_PRESENT;
        vld_d     = 1'b1;
        sel_idx_d = win_idx;
        sel_hit_d = win_any;
        addr_d    = win_any ? hdl_flat[win_idx*DATA_W +: DATA_W] : dflt_addr;
      end
      HS_PRESENT: state_d = HS_WAIT;
      HS_WAIT:    if (vec_ack) state_d = HS_IDLE;
      default:    state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q   <= HS_IDLE;
      vld_q     <= 1'b0;
      addr_q    <= '0;
      sel_idx_q <= '0;
      sel_hit_q <= 1'b0;
      irq_n_q   <= 1'b1;
    end else begin
      state_q   <= state_d;
      vld_q     <= vld_d;
      addr_q    <= addr_d;
      sel_idx_q <= sel_idx_d;
      sel_hit_q <= sel_hit_d;
      irq_n_q   <= irq_n_d;
    end
  end

  assign push     = (state_q == HS_WAIT) && vec_ack && sel_hit_q;
  assign vec_vld  = vld_q;
  assign vec_addr = addr_q;
  assign irq_n    = irq_n_q;

  irq_lvl_stack #(.DEPTH(LVLS), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_stack (
    .clk(clk), .rst_n(rst_core_n),
    .push(push), .push_lvl(lvl_flat[sel_idx_q*PRIO_W +: PRIO_W]),
    .push_idx(sel_idx_q), .pop(eos_pulse),
    .empty(stk_empty), .count(stk_count),
    .top_lvl(stk_top_lvl), .top_idx(stk_top_idx)
  );

  // R2/R3: a low request needs an enabled active source one cycle before
  a_r2_irq_has_source: assert property (@(posedge clk) disable iff (!rst_core_n)
    !irq_n |-> $past(|(src_irq & en_mask)));
  // R4: the valid strobe lasts a single cycle
  a_r4_vld_single: assert property (@(posedge clk) disable iff (!rst_core_n)
    vec_vld |=> !vec_vld);
  // R4: a strobe only follows a sampled request
  a_r4_vld_after_req: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(vec_vld) |-> $past(vec_req));
  // R5: the presented address holds while waiting for acknowledge
  a_r5_addr_frozen: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_q == HS_WAIT) |-> $stable(vec_addr));
  // R6: acknowledge arrives only while the controller waits for it
  a_r6_ack_in_wait: assert property (@(posedge clk) disable iff (!rst_core_n)
    vec_ack |-> (state_q == HS_WAIT));
endmodule

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] src_irq;
  logic        irq_n, vec_req, vec_vld, vec_ack;
  logic [31:0] vec_addr;
  logic        bus_wr, bus_rd;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  vec_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .irq_n(irq_n),
    .vec_req(vec_req), .vec_vld(vec_vld), .vec_addr(vec_addr), .vec_ack(vec_ack),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  localparam logic [31:0] DFLT = 32'h000D_EAD0;

  function automatic int lvl_of(int i);
    return (i * 5) % 8;
  endfunction

  function automatic logic [31:0] hdl_of(int i);
    return 32'h0000_1000 + 32'(i * 16);
  endfunction

  // Expected winner per R2/R3/R4: -1 when nothing is eligible.
  function automatic int exp_win(logic [15:0] s, logic [15:0] e, int top);
    int best = -1;
    int bl = -1;
    for (int i = 0; i < 16; i++)
      if (s[i] && e[i] && lvl_of(i) > top && lvl_of(i) > bl) begin
        best = i;
        bl = lvl_of(i);
      end
    return best;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_src(logic [15:0] s);
    @(negedge clk);
    src_irq = s;
    @(negedge clk);
  endtask

  // Full handshake; returns address and the strobe seen in both cycles.
  task automatic handshake(output logic [31:0] a, output logic v1, output logic v2,
                           input logic [15:0] swap_src, input bit do_swap);
    @(negedge clk);
    vec_req = 1'b1;
    @(negedge clk);
    v1 = vec_vld; a = vec_addr;
    if (do_swap) src_irq = swap_src;
    @(negedge clk);
    v2 = vec_vld;
    vec_ack = 1'b1; vec_req = 1'b0;
    @(negedge clk);
    vec_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic eos();
    bwrite(6'h02, 32'h1234);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd, a;
    logic v1, v2;
    int w;
    rst_n = 1'b0; src_irq = '0; vec_req = 1'b0; vec_ack = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 irq_n in reset", 32'(irq_n), 32'd1);
    check("R1 vld in reset", 32'(vec_vld), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 irq_n after reset", 32'(irq_n), 32'd1);
    bread(6'h00, rd); check("R1 enable reset", rd, 32'd0);
    bread(6'h03, rd); check("R1 status reset", rd, 32'd0);

    // Configuration and R9 read-back sweep
    for (int i = 0; i < 16; i++) begin
      bwrite(6'h10 + 6'(i), 32'hFFFF_FFF0 | 32'(lvl_of(i)));
      bwrite(6'h20 + 6'(i), hdl_of(i));
    end
    bwrite(6'h01, DFLT);
    bwrite(6'h00, 32'h0000_FFFF);
    for (int i = 0; i < 16; i++) begin
      bread(6'h10 + 6'(i), rd); check("R9 level readback", rd, 32'(lvl_of(i)));
      bread(6'h20 + 6'(i), rd); check("R9 handler readback", rd, hdl_of(i));
    end
    bread(6'h01, rd); check("R9 default readback", rd, DFLT);

    // Single source sweep: R2, R4, R6, R7
    for (int i = 0; i < 16; i++) begin
      set_src(16'(1 << i));
      check("R2 single low", 32'(irq_n), 32'd0);
      handshake(a, v1, v2, '0, 1'b0);
      check("R4 strobe", {30'd0, v1, v2}, 32'b10);
      check("R4 single addr", a, hdl_of(i));
      check("R6 masked after ack", 32'(irq_n), 32'd1);
      bread(6'h03, rd); check("R10 status one", rd, 32'h100 | 32'(i));
      eos();
      check("R7 restored", 32'(irq_n), 32'd0);
      set_src('0);
      check("R2 idle high", 32'(irq_n), 32'd1);
    end

    // Pair sweep with ties: R4
    for (int i = 0; i < 16; i++)
      for (int j = i + 1; j < 16; j++) begin
        set_src(16'((1 << i) | (1 << j)));
        w = exp_win(src_irq, 16'hFFFF, -1);
        handshake(a, v1, v2, '0, 1'b0);
        check("R4 pair winner", a, hdl_of(w));
        eos();
      end
    set_src('0);

    // Disabled sources: R3, R8
    for (int i = 0; i < 16; i++) begin
      bwrite(6'h00, 32'hFFFF & ~(32'd1 << i));
      set_src(16'(1 << i));
      check("R3 disabled high", 32'(irq_n), 32'd1);
      handshake(a, v1, v2, '0, 1'b0);
      check("R8 default addr", a, DFLT);
      bread(6'h03, rd); check("R8 no push", rd, 32'd0);
    end
    bwrite(6'h00, 32'h0000_FFFF);
    set_src('0);

    // Nesting: R10, R6, R7 (levels: src5=1, src1=5, src9=5, src3=7)
    set_src(16'h0020);
    handshake(a, v1, v2, '0, 1'b0); check("R10 first", a, hdl_of(5));
    set_src(16'h0022);
    check("R2 higher nests", 32'(irq_n), 32'd0);
    w = exp_win(src_irq, 16'hFFFF, lvl_of(5));
    handshake(a, v1, v2, '0, 1'b0); check("R10 second", a, hdl_of(w));
    bread(6'h03, rd); check("R10 depth two", rd, 32'h201);
    set_src(16'h0222);
    check("R6 equal level blocked", 32'(irq_n), 32'd1);
    set_src(16'h022A);
    check("R2 strictly higher passes", 32'(irq_n), 32'd0);
    set_src(16'h0222);
    eos();
    bread(6'h03, rd); check("R7 pop to one", rd, 32'h105);
    check("R7 level five reopened", 32'(irq_n), 32'd0);
    eos();
    bread(6'h03, rd); check("R7 empty", rd, 32'd0);
    set_src('0);

    // Freeze: R5
    set_src(16'h0001);
    handshake(a, v1, v2, 16'h0009, 1'b1);
    check("R5 frozen addr", a, hdl_of(0));
    check("R5 addr holds", vec_addr, hdl_of(0));
    bread(6'h03, rd); check("R5 recorded source", rd, 32'h100);
    eos();
    set_src('0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule